// File: doc/BRIEF.md
# Dual Programmable Interval Timer Unit

This block holds two independent down-counting timers and a small interrupt controller behind a word-wide register port. Each timer keeps a reload value (the divisor) and a control word. The control word carries two things: an operation code (load, hold or run) and a tick-source code. The tick-source code picks one of several rate strobes that arrive from outside, so the block itself never generates a clock.

A running timer counts down one step for each strobe of its chosen rate. When it expires it reloads from its divisor and keeps going, so it fires periodically. Each expiry sets that timer's bit in a raw status register. A mask register gates the raw bits onto a single level interrupt line. Software clears pending bits by writing ones to an acknowledge location, which always reads back as zero. A free-running cycle counter can also be read.

Bus requests are taken in a single cycle. Read data and the error flag are registered, so they appear one clock after the request.

Top module: `dual_interval_timer`

## Requirements
- R1: Full-word registers live at these byte offsets: divisor at 0x00 (timer0) and 0x10 (timer1), current count at 0x04 and 0x14, control at 0x08 and 0x18. Divisor and control read back what was written, the control word in bits [4:0]. Read data appears on the response port one cycle after the request.
- R2: Control bits [1:0] are the operation. Code 0 copies the divisor into the count and stops the timer. Code 1 stops the timer. Code 2 starts it. Code 3 behaves as code 1. A stopped count never changes on ticks.
- R3: A running timer moves on each selected tick. If the count is 2 or more, it decrements. If the count is 1 or 0, it reloads the divisor and signals an expiry. A divisor of N therefore gives one expiry every N ticks.
- R4: Control bits [4:2] select the rate. Code 4+k follows tick strobe bit k, for k from 0 to 3. Codes 0 to 3 select no strobe, and the count does not advance.
- R5: An expiry of timer0 sets raw status bit 0, and an expiry of timer1 sets raw status bit 1. The raw status is read at 0x50.
- R6: Writing the acknowledge location 0x4C clears every raw bit whose position is 1 in the written value. A read of 0x4C returns zero.
- R7: When an expiry and an acknowledge of the same bit happen in the same cycle, the bit stays set.
- R8: The mask is written and read at 0x48 (bit i enables timer i). The masked status at 0x54 equals raw AND mask. The irq output is high exactly when the masked status is nonzero, and it follows a mask write from the next cycle.
- R9: Offset 0x38 returns a free-running counter that increases by one every clock cycle.
- R10: An access whose byte enables are not all ones raises the error flag in the next cycle and changes no register.
- R11: A write to an unmapped offset (for example 0x24, 0x40 or 0x44) is ignored. A read of an unmapped offset returns zero.
- R12: After reset both timers are stopped, and the raw status and mask are zero, so irq is low and the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | NUM_RATES | Rate strobes, one per internal tick source |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset |
| req_be_i | input | 4 | Byte enables; all ones for a word access |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, registered |
| rsp_err_o | output | 1 | Error for a narrow access, registered |
| irq_o | output | 1 | Level interrupt from the masked status |

## Verification
Several rules are checked on every cycle by the assertions:
- A count that is stopped, or has no strobe selected, stays unchanged.
- An expiry leaves the count equal to the divisor.
- A raw bit rises only on an expiry, and an acknowledge clears its bits unless they expire in the same cycle.
- The time counter steps by one.
- A narrow access raises the error flag.

Some behaviours only the bench scenarios can show:
- The periodic reload count.
- Which strobe each rate code follows.
- The mask gating irq.
- The acknowledge location reading as zero.
- Narrow and unmapped writes leaving the registers untouched.

// File: rtl/dit_pkg.sv
package dit_pkg;
   localparam int unsigned BUS_W     = 32;
   localparam int unsigned ADDR_W    = 8;
   localparam int unsigned BE_W      = BUS_W / 8;
   // control word layout: [1:0] operation, [4:2] rate code
   localparam int unsigned RATE_LSB  = 2;
   localparam int unsigned RATE_W    = 3;
   localparam int unsigned CTRL_W    = RATE_LSB + RATE_W;
   localparam int unsigned RATE_BASE = 4;
   // per-timer sub-offsets (timer i occupies 0x10*i .. 0x10*i+0xF)
   localparam logic [3:0] SUB_DIV  = 4'h0;
   localparam logic [3:0] SUB_DATA = 4'h4;
   localparam logic [3:0] SUB_CTRL = 4'h8;
   // shared offsets
   localparam logic [ADDR_W-1:0] OFF_TIME   = 8'h38;
   localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h48;
   localparam logic [ADDR_W-1:0] OFF_ACK    = 8'h4C;
   localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h50;
   localparam logic [ADDR_W-1:0] OFF_MASKED = 8'h54;

   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_HOLD = 2'd1,
      OP_RUN  = 2'd2,
      OP_BAD  = 2'd3
   } op_e;
endpackage

// File: rtl/dit_channel.sv
module dit_channel
   import dit_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned NUM_RATES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RATES-1:0] tick_i,
   input  logic                 div_we_i,
   input  logic                 ctrl_we_i,
   input  logic [BUS_W-1:0]     wdata_i,
   output logic [CNT_W-1:0]     div_o,
   output logic [CTRL_W-1:0]    ctrl_o,
   output logic [CNT_W-1:0]     count_o,
   output logic                 expire_o
);
   localparam int unsigned MAX_RATES = (1 << RATE_W) - RATE_BASE;

   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("dit_channel: CNT_W must be 2..32");
   end
   if (NUM_RATES < 1 || NUM_RATES > MAX_RATES) begin : g_bad_rates
      $error("dit_channel: NUM_RATES out of range");
   end

   logic [CNT_W-1:0]  div_q, count_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic              run_q;
   logic              tick_sel;
   logic [RATE_W-1:0] rate;
   op_e               op_new;

   assign rate   = ctrl_q[RATE_LSB +: RATE_W];
   assign op_new = op_e'(wdata_i[1:0]);

   always_comb begin
      tick_sel = 1'b0;
      for (int r = 0; r < NUM_RATES; r++) begin
         if (int'(rate) == RATE_BASE + r) tick_sel = tick_i[r];
      end
   end

   assign expire_o = run_q && tick_sel && !ctrl_we_i && (count_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         ctrl_q  <= '0;
         count_q <= '0;
         run_q   <= 1'b0;
      end else begin
         if (div_we_i) div_q <= wdata_i[CNT_W-1:0];
         if (ctrl_we_i) begin
            ctrl_q <= wdata_i[CTRL_W-1:0];
            case (op_new)
               OP_LOAD: begin
                  count_q <= div_q;
                  run_q   <= 1'b0;
               end
               OP_RUN:  run_q <= 1'b1;
               default: run_q <= 1'b0;
            endcase
         end else if (run_q && tick_sel) begin
            count_q <= expire_o ? div_q : count_q - CNT_W'(1);
         end
      end
   end

   assign div_o   = div_q;
   assign ctrl_o  = ctrl_q;
   assign count_o = count_q;

   // R2 and R4: without a control write and a live selected tick the count holds
   a_r4_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_we_i && !(run_q && tick_sel)) |=> $stable(count_q));

   // R3: an expiry leaves the count at the divisor held before that edge
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (count_q == $past(div_q)));
endmodule

// File: rtl/dit_irq.sv
module dit_irq #(
   parameter int unsigned NUM_TIMERS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_TIMERS-1:0] expire_i,
   input  logic                  mask_we_i,
   input  logic                  ack_we_i,
   input  logic [NUM_TIMERS-1:0] wdata_i,
   output logic [NUM_TIMERS-1:0] raw_o,
   output logic [NUM_TIMERS-1:0] mask_o,
   output logic                  irq_o
);
   logic [NUM_TIMERS-1:0] raw_q, mask_q, clr;

   assign clr = ack_we_i ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         if (mask_we_i) mask_q <= wdata_i;
         raw_q <= (raw_q & ~clr) | expire_i;
      end
   end

   assign raw_o  = raw_q;
   assign mask_o = mask_q;
   assign irq_o  = |(raw_q & mask_q);

   // R5: a raw bit can only rise because its timer expired
   a_r5_set_by_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(expire_i)) == '0));

   // R6: acknowledged bits without a same-cycle expiry are cleared
   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we_i |=> ((raw_q & $past(wdata_i & ~expire_i)) == '0));

   // R7: an expiry always leaves its bit set, even under acknowledge
   a_r7_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_i != '0) |=> ((raw_q & $past(expire_i)) == $past(expire_i)));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import dit_pkg::*;
#(
   parameter int unsigned NUM_TIMERS = 2,
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned NUM_RATES  = 4,
   parameter int unsigned TIME_W     = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RATES-1:0] tick_i,
   input  logic                 req_valid_i,
   input  logic                 req_write_i,
   input  logic [ADDR_W-1:0]    req_addr_i,
   input  logic [BE_W-1:0]      req_be_i,
   input  logic [BUS_W-1:0]     req_wdata_i,
   output logic [BUS_W-1:0]     rsp_rdata_o,
   output logic                 rsp_err_o,
   output logic                 irq_o
);
   if (NUM_TIMERS < 1 || NUM_TIMERS > 3) begin : g_bad_timers
      $error("dual_interval_timer: NUM_TIMERS must be 1..3");
   end
   if (TIME_W < 1 || TIME_W > BUS_W) begin : g_bad_time
      $error("dual_interval_timer: TIME_W must be 1..32");
   end

   logic full_word, acc, wr, rd;
   logic [3:0] sub;
   logic [NUM_TIMERS-1:0]             expire;
   logic [NUM_TIMERS-1:0][CNT_W-1:0]  div_a, cnt_a;
   logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctrl_a;
   logic [NUM_TIMERS-1:0]             raw, mask;
   logic [TIME_W-1:0]                 time_q;
   logic [BUS_W-1:0]                  rd_mux, rdata_q;
   logic                              err_q;

   assign full_word = (req_be_i == '1);
   assign acc       = req_valid_i && full_word;
   assign wr        = acc && req_write_i;
   assign rd        = acc && !req_write_i;
   assign sub       = req_addr_i[3:0];

   for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
      logic hit;
      assign hit = (req_addr_i[7:4] == 4'(i));
      dit_channel #(.CNT_W(CNT_W), .NUM_RATES(NUM_RATES)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick_i),
         .div_we_i  (wr && hit && sub == SUB_DIV),
         .ctrl_we_i (wr && hit && sub == SUB_CTRL),
         .wdata_i   (req_wdata_i),
         .div_o     (div_a[i]),
         .ctrl_o    (ctrl_a[i]),
         .count_o   (cnt_a[i]),
         .expire_o  (expire[i])
      );
   end

   dit_irq #(.NUM_TIMERS(NUM_TIMERS)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire_i  (expire),
      .mask_we_i (wr && req_addr_i == OFF_MASK),
      .ack_we_i  (wr && req_addr_i == OFF_ACK),
      .wdata_i   (req_wdata_i[NUM_TIMERS-1:0]),
      .raw_o     (raw),
      .mask_o    (mask),
      .irq_o     (irq_o)
   );

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_TIMERS; i++) begin
         if (req_addr_i[7:4] == 4'(i)) begin
            case (sub)
               SUB_DIV:  rd_mux = BUS_W'(div_a[i]);
               SUB_DATA: rd_mux = BUS_W'(cnt_a[i]);
               SUB_CTRL: rd_mux = BUS_W'(ctrl_a[i]);
               default:  ;
            endcase
         end
      end
      case (req_addr_i)
         OFF_TIME:   rd_mux = BUS_W'(time_q);
         OFF_MASK:   rd_mux = BUS_W'(mask);
         OFF_RAW:    rd_mux = BUS_W'(raw);
         OFF_MASKED: rd_mux = BUS_W'(raw & mask);
         default:    ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q  <= '0;
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         time_q <= time_q + TIME_W'(1);
         err_q  <= req_valid_i && !full_word;
         if (rd) rdata_q <= rd_mux;
      end
   end

   assign rsp_rdata_o = rdata_q;
   assign rsp_err_o   = err_q;

   // R10: a narrow access is flagged in the following cycle
   a_r10_narrow_err: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_be_i != '1) |=> rsp_err_o);

   // R9: the time counter advances by exactly one per cycle
   a_r9_time_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (time_q == $past(time_q) + TIME_W'(1)));

   // R12: the first cycle out of reset shows no interrupt and no error
   a_r12_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_o && !rsp_err_o));
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tick = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_err;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   int          q_due[$];
   logic [31:0] q_exp[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   dual_interval_timer u_dual_interval_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
      .req_be_i(req_be), .req_wdata_i(req_wdata),
      .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err), .irq_o(irq)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data when its response is due
   always @(negedge clk) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
         check(q_tag[0], rsp_rdata, q_exp[0]);
         void'(q_due.pop_front());
         void'(q_exp.pop_front());
         void'(q_tag.pop_front());
      end
   end

   task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [3:0] tk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      req_be = be; tick = tk;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; tick = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus(1'b1, a, d, 4'hF, 4'h0);
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      q_due.push_back(cyc + 1);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      bus(1'b0, a, '0, 4'hF, 4'h0);
   endtask

   task automatic pulse(input logic [3:0] tk);
      tick = tk;
      @(posedge clk);
      @(negedge clk);
      tick = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL R12 watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] t0, t1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R12 reset state
      check("R12 irq", {31'd0, irq}, 32'd0);
      check("R12 err", {31'd0, rsp_err}, 32'd0);
      rd(8'h48, 0, "R12 mask");
      rd(8'h50, 0, "R12 raw");
      rd(8'h04, 0, "R12 count");

      // R1 register access, R2 load
      wr(8'h00, 3);
      rd(8'h00, 3, "R1 divisor");
      wr(8'h08, 32'h10);             // rate 4, load
      rd(8'h04, 3, "R2 load copies divisor");
      rd(8'h08, 32'h10, "R1 control");
      pulse(4'h1);
      rd(8'h04, 3, "R2 loaded timer stopped");

      // R3 run and expiry, R5 raw bit 0
      wr(8'h08, 32'h12);             // rate 4, run
      pulse(4'h1);
      rd(8'h04, 2, "R3 decrement");
      pulse(4'h1);
      pulse(4'h1);
      rd(8'h04, 3, "R3 reload after expiry");
      rd(8'h50, 1, "R5 timer0 raw bit");
      check("R8 masked off irq", {31'd0, irq}, 32'd0);

      // R8 mask
      wr(8'h48, 1);
      check("R8 irq after mask", {31'd0, irq}, 32'd1);
      rd(8'h54, 1, "R8 masked status");

      // R6 acknowledge
      wr(8'h4C, 1);
      check("R6 irq cleared", {31'd0, irq}, 32'd0);
      rd(8'h50, 0, "R6 raw cleared");
      rd(8'h4C, 0, "R6 ack reads zero");

      // R2 hold and illegal op
      pulse(4'h1);                   // count 2
      wr(8'h08, 32'h11);             // hold
      pulse(4'h1);
      rd(8'h04, 2, "R2 hold");
      wr(8'h08, 32'h13);             // op 3
      pulse(4'h1);
      rd(8'h04, 2, "R2 op3 holds");

      // R4 rate select
      wr(8'h08, 32'h16);             // rate 5 (tick bit 1), run
      pulse(4'h1);
      rd(8'h04, 2, "R4 other strobe ignored");
      pulse(4'h2);
      rd(8'h04, 1, "R4 selected strobe");
      wr(8'h08, 32'h02);             // rate 0, run
      pulse(4'hF);
      rd(8'h04, 1, "R4 disabled rate");

      // R7 expiry beats acknowledge
      wr(8'h08, 32'h16);
      pulse(4'h2);                   // expire, count 3, raw0 set
      pulse(4'h2);
      pulse(4'h2);                   // count 1
      bus(1'b1, 8'h4C, 1, 4'hF, 4'h2);
      rd(8'h50, 1, "R7 expiry wins");
      rd(8'h04, 3, "R7 reload");
      wr(8'h4C, 1);
      rd(8'h50, 0, "R6 second ack");

      // R5 timer1 raw bit 1
      wr(8'h10, 2);
      wr(8'h18, 32'h1C);             // rate 7, load
      wr(8'h18, 32'h1E);             // run
      pulse(4'h8);
      pulse(4'h8);
      rd(8'h50, 2, "R5 timer1 raw bit");
      rd(8'h04, 3, "R5 timer0 untouched");
      wr(8'h48, 2);
      check("R8 timer1 irq", {31'd0, irq}, 32'd1);
      wr(8'h48, 0);
      check("R8 mask off", {31'd0, irq}, 32'd0);

      // R10 narrow access
      bus(1'b1, 8'h00, 7, 4'h3, 4'h0);
      check("R10 err flag", {31'd0, rsp_err}, 32'd1);
      rd(8'h00, 3, "R10 no effect");
      check("R10 err clears", {31'd0, rsp_err}, 32'd0);

      // R11 unmapped
      wr(8'h24, 5);
      rd(8'h24, 0, "R11 unmapped read");
      wr(8'h40, 32'h1FF);
      rd(8'h40, 0, "R11 unmapped 0x40");
      rd(8'h50, 2, "R11 raw untouched");

      // R9 time register
      bus(1'b0, 8'h38, 0, 4'hF, 4'h0);
      t0 = rsp_rdata;
      bus(1'b0, 8'h38, 0, 4'hF, 4'h0);
      t1 = rsp_rdata;
      check("R9 time step", t1 - t0, 32'd1);

      repeat (2) @(negedge clk);
      check("R1 scoreboard drained", q_due.size(), 32'd0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule